// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block is the register-mapped command front end of an SD card host. Software loads a 32-bit argument and then writes a 16-bit command word. When that word has its start bit set, the block presents a request (command index plus argument) to a card-side engine. The request is held until the engine answers with a one-cycle response strobe. The strobe carries a byte count, up to sixteen response bytes and an error flag.

On the strobe, the block checks the byte count against the response type the command asked for. A good answer is repacked into four 32-bit response words with big-endian byte order. A bad answer leaves those words alone and latches a failure flag in the command word and a command-timeout bit in the status register. Busy-wait commands can raise a busy interrupt when they complete. The interrupt line is the OR of the three interrupt bits in status. Status bits are cleared by writing ones.

Top module: `sd_cmd_frontend`

## Requirements
- R1: After synchronous reset, every register reads zero, `card_req` is low and `irq` is low.
- R2: A write to offset 0x00 with bit 15 set issues a command. From the next cycle `card_req` is high, `card_index` carries bits 5:0 and `card_arg` carries the argument register. Bit 15 reads back as one while the command is pending. It reads as zero after the response strobe, and `card_req` drops in the same cycle.
- R3: Command word bit 10 means no response is expected. When a response is expected, the answer is an error if the byte count is anything but 4 or 16, or if it is 4 while bit 9 (long response) is set. A 16-byte answer is accepted whether or not bit 9 is set.
- R4: On an error the block sets command word bit 14 and status bit 6 (0x40), and leaves the response words unchanged.
- R5: A good 4-byte answer loads response word 0 (offset 0x10) big-endian from bytes 0..3, and clears words 1..3 (offsets 0x14, 0x18, 0x1C). Response byte k sits on `card_rsp_data[8k+7:8k]`.
- R6: A good 16-byte answer loads word 0 from bytes 12..15, word 1 from bytes 8..11, word 2 from bytes 4..7 and word 3 from bytes 0..3, each big-endian.
- R7: When bit 10 of the command word is set, the byte count is not checked and the response words stay unchanged. Only `card_err` makes such a command fail. With a response expected, `card_err` is also an error.
- R8: When a command with bit 11 (busy-wait) completes without error and configuration bit 10 (offset 0x38) is set, status bit 10 (0x400) is set. It is not set after an error or with the enable clear.
- R9: A write to status (offset 0x20) clears exactly the bits written as one. If a bit is set and cleared in the same cycle, the set wins.
- R10: `irq` is high exactly when any of status bits 10, 9 or 8 is set, and it changes in the same cycle as the status register.
- R11: While a command is pending, writes to the command word are ignored: the readback, `card_index` and `card_arg` keep their values. Writes to the argument register still take effect but do not alter `card_arg`.
- R12: Argument (0x04) and configuration bit 10 (0x38) read back as written. Unmapped offsets read zero. Read data appears one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| card_req | output | 1 | Command pending toward the card engine |
| card_index | output | 6 | Command index of the pending command |
| card_arg | output | 32 | Argument captured at issue |
| card_rsp_valid | input | 1 | One-cycle response strobe |
| card_rsp_len | input | 5 | Response byte count (0..16) |
| card_rsp_data | input | 128 | Response bytes, byte k at bits 8k+7:8k |
| card_err | input | 1 | Card-side failure indication |
| irq | output | 1 | Interrupt, OR of status bits 10:8 |

## Verification
Some properties are checked by assertions on every cycle. A pending request holds with a stable command word until the strobe. Acceptance always clears the start bit and drops the request. An error always raises both failure flags. A no-response completion never disturbs the response words. The busy interrupt rises only after an error-free completion. Other behaviour can only be shown by the directed scenarios: the exact byte reordering for 4- and 16-byte answers, each rejected byte count, the set-wins rule for write-one-to-clear, and readback of the argument and configuration bits.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int REG_W      = 32;
  localparam int AW         = 8;
  localparam int RSP_BYTES  = 16;
  localparam int SHORT_BYTES = 4;
  localparam int RSP_WORDS  = RSP_BYTES / 4;
  localparam int LEN_W      = $clog2(RSP_BYTES + 1);
  localparam int IDX_W      = 6;
  localparam int STAT_W     = 11;

  localparam logic [AW-1:0] OFS_CMD  = 8'h00;
  localparam logic [AW-1:0] OFS_ARG  = 8'h04;
  localparam logic [AW-1:0] OFS_RSP0 = 8'h10;
  localparam logic [AW-1:0] OFS_STAT = 8'h20;
  localparam logic [AW-1:0] OFS_CFG  = 8'h38;

  localparam int CB_LONG   = 9;
  localparam int CB_NORSP  = 10;
  localparam int CB_BUSY   = 11;
  localparam int CB_FAIL   = 14;
  localparam int CB_START  = 15;

  localparam int SB_TIMEOUT = 6;
  localparam int SB_BUSYIRQ = 10;
  localparam int CFG_BUSYEN = 10;
endpackage

// File: rtl/sd_rsp_check.sv
module sd_rsp_check
  import sd_cmd_pkg::*;
#(
  parameter int LONG_N  = RSP_BYTES,
  parameter int SHORT_N = SHORT_BYTES
) (
  input  logic [LEN_W-1:0] len,
  input  logic             want_long,
  input  logic             no_rsp,
  input  logic             card_err,
  output logic             bad
);
  logic len_ok;
  always_comb begin
    len_ok = (len == LEN_W'(SHORT_N) && !want_long) || (len == LEN_W'(LONG_N));
    bad    = card_err || (!no_rsp && !len_ok);
  end
endmodule

// File: rtl/sd_rsp_pack.sv
module sd_rsp_pack
  import sd_cmd_pkg::*;
#(
  parameter int NBYTES = RSP_BYTES
) (
  input  logic [NBYTES*8-1:0]        bytes_in,
  input  logic                       is_short,
  output logic [NBYTES/4-1:0][31:0]  words
);
  localparam int NW = NBYTES / 4;

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int BASE = 4 * (NW - 1 - w);
    logic [31:0] long_w;
    logic [31:0] short_w;
    assign long_w = {bytes_in[8*BASE+7 -: 8], bytes_in[8*(BASE+1)+7 -: 8],
                     bytes_in[8*(BASE+2)+7 -: 8], bytes_in[8*(BASE+3)+7 -: 8]};
    if (w == 0) begin : g_first
      assign short_w = {bytes_in[7:0], bytes_in[15:8], bytes_in[23:16], bytes_in[31:24]};
    end else begin : g_rest
      assign short_w = '0;
    end
    assign words[w] = is_short ? short_w : long_w;
  end
endmodule

// File: rtl/sd_cmd_frontend.sv
module sd_cmd_frontend
  import sd_cmd_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        rdata,
  output logic                    card_req,
  output logic [IDX_W-1:0]        card_index,
  output logic [REG_W-1:0]        card_arg,
  input  logic                    card_rsp_valid,
  input  logic [LEN_W-1:0]        card_rsp_len,
  input  logic [RSP_BYTES*8-1:0]  card_rsp_data,
  input  logic                    card_err,
  output logic                    irq
);
  logic [15:0]                    cmd_q;
  logic [REG_W-1:0]               arg_q;
  logic [STAT_W-1:0]              stat_q, stat_n;
  logic                           busy_en_q;
  logic [RSP_WORDS-1:0][31:0]     rsp_q;
  logic [RSP_WORDS-1:0][31:0]     rsp_packed;
  logic                           pend_q;
  logic [REG_W-1:0]               req_arg_q;
  logic                           irq_q;
  logic [REG_W-1:0]               rdata_q;
  logic                           accept, rsp_bad;
  logic [STAT_W-1:0]              stat_set, stat_clr;
  logic [REG_W-1:0]               rd_mux;

  assign accept = pend_q && card_rsp_valid;

  sd_rsp_check #(.LONG_N(RSP_BYTES), .SHORT_N(SHORT_BYTES)) u_check (
    .len(card_rsp_len), .want_long(cmd_q[CB_LONG]), .no_rsp(cmd_q[CB_NORSP]),
    .card_err(card_err), .bad(rsp_bad)
  );

  sd_rsp_pack #(.NBYTES(RSP_BYTES)) u_pack (
    .bytes_in(card_rsp_data),
    .is_short(card_rsp_len == LEN_W'(SHORT_BYTES)),
    .words(rsp_packed)
  );

  always_comb begin
    stat_set = '0;
    if (accept && rsp_bad) stat_set[SB_TIMEOUT] = 1'b1;
    if (accept && !rsp_bad && cmd_q[CB_BUSY] && busy_en_q) stat_set[SB_BUSYIRQ] = 1'b1;
    stat_clr = (wr_en && addr == OFS_STAT) ? wdata[STAT_W-1:0] : '0;
    stat_n   = (stat_q & ~stat_clr) | stat_set;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CMD:          rd_mux = {16'h0, cmd_q};
      OFS_ARG:          rd_mux = arg_q;
      OFS_STAT:         rd_mux = {{(REG_W-STAT_W){1'b0}}, stat_q};
      OFS_CFG:          rd_mux = REG_W'(busy_en_q) << CFG_BUSYEN;
      default: begin
        for (int w = 0; w < RSP_WORDS; w++)
          if (addr == OFS_RSP0 + AW'(4*w)) rd_mux = rsp_q[w];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      arg_q     <= '0;
      stat_q    <= '0;
      busy_en_q <= 1'b0;
      rsp_q     <= '0;
      pend_q    <= 1'b0;
      req_arg_q <= '0;
      irq_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      rdata_q <= rd_en ? rd_mux : '0;
      stat_q  <= stat_n;
      irq_q   <= |stat_n[10:8];
      if (wr_en && addr == OFS_ARG) arg_q <= wdata;
      if (wr_en && addr == OFS_CFG) busy_en_q <= wdata[CFG_BUSYEN];
      if (wr_en && addr == OFS_CMD && !pend_q) begin
        cmd_q <= wdata[15:0];
        if (wdata[CB_START]) begin
          pend_q    <= 1'b1;
          req_arg_q <= arg_q;
        end
      end
      if (accept) begin
        pend_q          <= 1'b0;
        cmd_q[CB_START] <= 1'b0;
        if (rsp_bad) cmd_q[CB_FAIL] <= 1'b1;
        else if (!cmd_q[CB_NORSP]) rsp_q <= rsp_packed;
      end
    end
  end

  assign rdata      = rdata_q;
  assign card_req   = pend_q;
  assign card_index = cmd_q[IDX_W-1:0];
  assign card_arg   = req_arg_q;
  assign irq        = irq_q;

  AST_START_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!cmd_q[CB_START] && !card_req)); // R2
  AST_ERROR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (accept && rsp_bad) |=> (cmd_q[CB_FAIL] && stat_q[SB_TIMEOUT])); // R4
  AST_NORSP_KEEPS_WORDS: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_q[CB_NORSP]) |=> $stable(rsp_q)); // R7
  AST_BUSY_ONLY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[SB_BUSYIRQ]) |-> ($past(accept) && !$past(rsp_bad))); // R8
  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (card_req && !card_rsp_valid) |=> (card_req && $stable(cmd_q) && $stable(card_arg))); // R11
endmodule

// File: tb/sd_cmd_frontend_tb.sv
module sd_cmd_frontend_tb;
  logic         clk = 0;
  logic         rst = 1;
  logic         wr_en = 0, rd_en = 0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         card_req;
  logic [5:0]   card_index;
  logic [31:0]  card_arg;
  logic         card_rsp_valid = 0;
  logic [4:0]   card_rsp_len = '0;
  logic [127:0] card_rsp_data = '0;
  logic         card_err = 0;
  logic         irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sd_cmd_frontend u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .card_req(card_req), .card_index(card_index), .card_arg(card_arg),
    .card_rsp_valid(card_rsp_valid), .card_rsp_len(card_rsp_len),
    .card_rsp_data(card_rsp_data), .card_err(card_err), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  function automatic logic [127:0] mk(logic [7:0] base);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*k +: 8] = base + 8'(k);
    return r;
  endfunction

  task automatic reply(logic [4:0] len, logic [127:0] d, logic e);
    @(negedge clk);
    card_rsp_valid = 1; card_rsp_len = len; card_rsp_data = d; card_err = e;
    @(negedge clk);
    card_rsp_valid = 0; card_err = 0;
  endtask

  task automatic t_reset();
    chk("R1 req", 32'(card_req), 0);
    chk("R1 irq", 32'(irq), 0);
    rd_chk("R1 cmd", 8'h00, 0);
    rd_chk("R1 stat", 8'h20, 0);
    for (int w = 0; w < 4; w++) rd_chk("R1 rsp", 8'h10 + 8'(4*w), 0);
  endtask

  task automatic t_regs();
    wr(8'h04, 32'hCAFE0001);
    rd_chk("R12 arg", 8'h04, 32'hCAFE0001);
    wr(8'h38, 32'hFFFF_FFFF);
    rd_chk("R12 cfg", 8'h38, 32'h400);
    wr(8'h38, 0);
    rd_chk("R12 cfg clr", 8'h38, 0);
    rd_chk("R12 unmapped", 8'h08, 0);
  endtask

  task automatic t_short();
    wr(8'h04, 32'h12345678);
    wr(8'h00, 32'h8011);
    chk("R2 req", 32'(card_req), 1);
    chk("R2 index", 32'(card_index), 32'h11);
    chk("R2 arg", card_arg, 32'h12345678);
    rd_chk("R2 start pending", 8'h00, 32'h8011);
    reply(5'd4, mk(8'hA0), 0);
    chk("R2 req drop", 32'(card_req), 0);
    rd_chk("R2 start cleared", 8'h00, 32'h0011);
    rd_chk("R5 word0", 8'h10, 32'hA0A1A2A3);
    rd_chk("R5 word1", 8'h14, 0);
    rd_chk("R5 word3", 8'h1C, 0);
  endtask

  task automatic t_inflight();
    wr(8'h04, 32'h00000AAA);
    wr(8'h00, 32'h8005);
    wr(8'h00, 32'h8022);
    wr(8'h04, 32'h00000BBB);
    chk("R11 index", 32'(card_index), 5);
    chk("R11 arg", card_arg, 32'hAAA);
    rd_chk("R11 cmd", 8'h00, 32'h8005);
    rd_chk("R11 arg reg", 8'h04, 32'hBBB);
    reply(5'd4, mk(8'hB0), 0);
    rd_chk("R11 done", 8'h00, 32'h0005);
  endtask

  task automatic t_long();
    wr(8'h00, 32'h8202);
    reply(5'd16, mk(8'h10), 0);
    rd_chk("R6 word0", 8'h10, 32'h1C1D1E1F);
    rd_chk("R6 word1", 8'h14, 32'h18191A1B);
    rd_chk("R6 word2", 8'h18, 32'h14151617);
    rd_chk("R6 word3", 8'h1C, 32'h10111213);
  endtask

  task automatic t_errors();
    wr(8'h00, 32'h8202);
    reply(5'd4, mk(8'h40), 0);
    rd_chk("R4 fail flag", 8'h00, 32'h4202);
    rd_chk("R4 timeout", 8'h20, 32'h40);
    rd_chk("R4 words kept", 8'h10, 32'h1C1D1E1F);
    wr(8'h20, 32'h40);
    rd_chk("R9 w1c", 8'h20, 0);
    wr(8'h00, 32'h8003);
    reply(5'd0, mk(8'h50), 0);
    rd_chk("R3 len0", 8'h00, 32'h4003);
    wr(8'h20, 32'h40);
    wr(8'h00, 32'h8003);
    reply(5'd8, mk(8'h50), 0);
    rd_chk("R3 len8", 8'h00, 32'h4003);
    rd_chk("R3 len8 word0", 8'h10, 32'h1C1D1E1F);
    wr(8'h20, 32'h40);
    wr(8'h00, 32'h8003);
    reply(5'd4, mk(8'h60), 1);
    rd_chk("R7 card err expected rsp", 8'h20, 32'h40);
    wr(8'h20, 32'h40);
    wr(8'h00, 32'h8003);
    reply(5'd16, mk(8'h20), 0);
    rd_chk("R3 16 short ok", 8'h00, 32'h0003);
    rd_chk("R3 16 short stat", 8'h20, 0);
    rd_chk("R3 16 short word3", 8'h1C, 32'h20212223);
  endtask

  task automatic t_norsp();
    wr(8'h00, 32'h8407);
    reply(5'd0, mk(8'h70), 0);
    rd_chk("R7 no check", 8'h00, 32'h0407);
    rd_chk("R7 words kept", 8'h10, 32'h2C2D2E2F);
    wr(8'h00, 32'h8407);
    reply(5'd4, mk(8'h70), 1);
    rd_chk("R7 err", 8'h00, 32'h4407);
    rd_chk("R7 err stat", 8'h20, 32'h40);
    wr(8'h20, 32'h40);
  endtask

  task automatic t_busy();
    wr(8'h00, 32'h8C08);
    reply(5'd0, mk(0), 0);
    rd_chk("R8 disabled", 8'h20, 0);
    chk("R10 irq low", 32'(irq), 0);
    wr(8'h38, 32'h400);
    wr(8'h00, 32'h8C08);
    reply(5'd0, mk(0), 1);
    rd_chk("R8 error no busy", 8'h20, 32'h40);
    chk("R10 irq low err", 32'(irq), 0);
    wr(8'h20, 32'h40);
    wr(8'h00, 32'h8C08);
    @(negedge clk);
    card_rsp_valid = 1; card_rsp_len = 0; card_err = 0;
    @(negedge clk);
    card_rsp_valid = 0;
    chk("R10 irq same cycle", 32'(irq), 1);
    rd_chk("R8 busy set", 8'h20, 32'h400);
    wr(8'h20, 32'h40);
    rd_chk("R9 other bit kept", 8'h20, 32'h400);
    chk("R10 irq held", 32'(irq), 1);
    wr(8'h20, 32'h400);
    chk("R10 irq cleared", 32'(irq), 0);
    wr(8'h00, 32'h8C08);
    @(negedge clk);
    card_rsp_valid = 1; card_rsp_len = 0;
    wr_en = 1; addr = 8'h20; wdata = 32'h400;
    @(negedge clk);
    card_rsp_valid = 0; wr_en = 0;
    rd_chk("R9 set wins", 8'h20, 32'h400);
    wr(8'h20, 32'h400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_short();
    t_inflight();
    t_long();
    t_errors();
    t_norsp();
    t_busy();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule